// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block sits between a processor's memory request path and the DRAM and expansion-bus controllers of a chipset. It holds the attribute registers for the legacy address window from 0xA0000 up to 0xFFFFF. For every memory address presented with its read/write direction, it returns one of three routing results: serve the access from DRAM, drop it (a write that hits a segment marked DRAM read-only), or forward it to the expansion bus.

The window has three parts. The first is a 128 KiB video area. It is opened to DRAM either by an unconditional open bit, or by an enable bit that only counts while the system-management mode input is high. The second is twelve 16 KiB option segments starting at 0xC0000. The third is one 64 KiB boot segment at 0xF0000. Each option segment and the boot segment carries a 2-bit attribute. Attributes are packed two to a byte in the configuration space, and the byte-wide configuration port writes and reads them. Addresses outside the window always go to DRAM.

The decode is combinational from the registered attribute state. A configuration write therefore steers requests from the following clock cycle. A change on the mode input acts in the same cycle.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset, configuration offset 0x72 reads 0x02 and offsets 0x59 to 0x5F read 0x00. Every segment of the window at 0xA0000 to 0xFFFFF then routes to the expansion bus (`tgt_o` = 1).
- R2: An address below 0xA0000, or at or above 0x100000, routes to DRAM (`tgt_o` = 0) whatever the register contents and the mode input.
- R3: The boot segment 0xF0000 to 0xFFFFF takes its attribute from bits [5:4] of offset 0x59. The other bits of that byte have no effect on it.
- R4: Option segment i (0 to 11), at 0xC0000 + 0x4000*i, takes its attribute from offset 0x5A + (i >> 1). Even i uses bits [1:0] of that byte and odd i uses bits [5:4]. Bits [3:2] and [7:6] have no effect.
- R5: Attribute 3 routes reads and writes to DRAM (`tgt_o` = 0). Attribute 1 routes reads to DRAM and reports writes as dropped (`tgt_o` = 2). Attributes 0 and 2 route to the expansion bus (`tgt_o` = 1). A read never reports dropped.
- R6: While bit 6 of offset 0x72 is set, the video area 0xA0000 to 0xBFFFF routes to DRAM.
- R7: While bit 6 of 0x72 is clear, the video area routes to DRAM only when bit 3 of 0x72 is set and `smm_i` is high. Otherwise it routes to the bus. A change on `smm_i` acts in the same cycle.
- R8: A configuration write to 0x59 to 0x5F or to 0x72 stores the byte. The new value changes the decode and the readback from the next cycle, and not in the cycle of the write.
- R9: Writes to any other configuration offset are ignored. Such offsets read 0x00, and the stored registers and the decode stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_off_i | input | 8 | Configuration byte offset for write and read |
| cfg_wdata_i | input | 8 | Configuration write byte |
| cfg_rdata_o | output | 8 | Configuration read byte at `cfg_off_i` (combinational) |
| smm_i | input | 1 | System-management mode active |
| mem_addr_i | input | ADDR_W | Memory request address |
| mem_we_i | input | 1 | Request is a write |
| tgt_o | output | 2 | Routing result: 0 DRAM, 1 expansion bus, 2 write dropped |

## Verification
Requests are swept across both edges of every option segment and of the boot and video areas. The attribute bytes are given distinct codes in their low and high nibbles, so a swapped nibble or an off-by-one segment index lands on the wrong code. Each attribute is tried with both a read and a write, which separates read-only from read/write and from the bus codes 0 and 2. The video area is tried with the open bit, with the mode-qualified bit and the mode input high and low, and with both bits clear. A long randomized stretch of writes and requests around the window boundaries is then compared each clock against a behavioural model. That stretch also catches writes that wrongly reach unlisted offsets.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_BUS  = 2'd1,
        TGT_DROP = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        RG_PLAIN = 2'd0,
        RG_VIDEO = 2'd1,
        RG_SEG   = 2'd2
    } region_e;

    localparam logic [1:0] ATTR_RO = 2'd1;
    localparam logic [1:0] ATTR_RW = 2'd3;

    localparam logic [7:0] BANK_OFF  = 8'h59;
    localparam logic [7:0] SMC_OFF   = 8'h72;
    localparam logic [7:0] SMC_RESET = 8'h02;
    localparam int         SMC_OPEN_BIT = 6;
    localparam int         SMC_SMM_BIT  = 3;

    localparam logic [31:0] VIDEO_BASE = 32'h000A_0000;
    localparam logic [31:0] SEG_BASE   = 32'h000C_0000;
    localparam logic [31:0] BOOT_BASE  = 32'h000F_0000;
    localparam logic [31:0] WIN_END    = 32'h0010_0000;
endpackage

// File: rtl/lrd_cfg_bank.sv
module lrd_cfg_bank
    import lrd_pkg::*;
#(
    parameter int NBYTES = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [7:0]          off,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    output logic [NBYTES*8-1:0] bank_q,
    output logic [7:0]          smc_q
);
    logic [NBYTES-1:0] hit;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        assign hit[k] = (off == 8'(BANK_OFF + 8'(k)));
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[8*k +: 8] <= 8'h00;
            else if (we && hit[k])
                bank_q[8*k +: 8] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            smc_q <= SMC_RESET;
        else if (we && off == SMC_OFF)
            smc_q <= wdata;
    end

    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < NBYTES; k++)
            if (hit[k]) rdata = bank_q[8*k +: 8];
        if (off == SMC_OFF) rdata = smc_q;
    end
endmodule

// File: rtl/lrd_seg_lookup.sv
module lrd_seg_lookup
    import lrd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_SEG   = 12,
    parameter int SEG_SHIFT = 14,
    parameter int NBYTES    = 7
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NBYTES*8-1:0] bank_q,
    output region_e             region,
    output logic [1:0]          attr
);
    localparam int SEG_IW = $clog2(NUM_SEG);

    logic [1:0]        seg_attr [NUM_SEG];
    logic [SEG_IW-1:0] idx;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        assign seg_attr[g] = bank_q[8*(1 + g/2) + 4*(g%2) +: 2];
    end

    assign idx = SEG_IW'((addr - ADDR_W'(SEG_BASE)) >> SEG_SHIFT);

    always_comb begin
        region = RG_PLAIN;
        attr   = ATTR_RW;
        if (addr >= ADDR_W'(VIDEO_BASE) && addr < ADDR_W'(SEG_BASE)) begin
            region = RG_VIDEO;
        end else if (addr >= ADDR_W'(SEG_BASE) && addr < ADDR_W'(BOOT_BASE)) begin
            region = RG_SEG;
            for (int k = 0; k < NUM_SEG; k++)
                if (idx == SEG_IW'(k)) attr = seg_attr[k];
        end else if (addr >= ADDR_W'(BOOT_BASE) && addr < ADDR_W'(WIN_END)) begin
            region = RG_SEG;
            attr   = bank_q[5:4];
        end
    end
endmodule

// File: rtl/lrd_target_sel.sv
module lrd_target_sel
    import lrd_pkg::*;
(
    input  region_e    region,
    input  logic [1:0] attr,
    input  logic       we,
    input  logic       smm,
    input  logic [7:0] smc_q,
    output tgt_e       tgt
);
    logic video_open;

    assign video_open = smc_q[SMC_OPEN_BIT] || (smm && smc_q[SMC_SMM_BIT]);

    always_comb begin
        unique case (region)
            RG_VIDEO: tgt = video_open ? TGT_DRAM : TGT_BUS;
            RG_SEG: begin
                if (attr == ATTR_RW)
                    tgt = TGT_DRAM;
                else if (attr == ATTR_RO)
                    tgt = we ? TGT_DROP : TGT_DRAM;
                else
                    tgt = TGT_BUS;
            end
            default: tgt = TGT_DRAM;
        endcase
    end
endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
    import lrd_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_SEG   = 12,
    parameter int SEG_SHIFT = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic [7:0]        cfg_off_i,
    input  logic [7:0]        cfg_wdata_i,
    output logic [7:0]        cfg_rdata_o,
    input  logic              smm_i,
    input  logic [ADDR_W-1:0] mem_addr_i,
    input  logic              mem_we_i,
    output logic [1:0]        tgt_o
);
    localparam int NBYTES = 1 + (NUM_SEG + 1) / 2;

    logic [NBYTES*8-1:0] bank_q;
    logic [7:0]          smc_q;
    region_e             region;
    logic [1:0]          attr;
    tgt_e                tgt;

    lrd_cfg_bank #(.NBYTES(NBYTES)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(cfg_we_i), .off(cfg_off_i),
        .wdata(cfg_wdata_i), .rdata(cfg_rdata_o), .bank_q(bank_q), .smc_q(smc_q)
    );

    lrd_seg_lookup #(
        .ADDR_W(ADDR_W), .NUM_SEG(NUM_SEG), .SEG_SHIFT(SEG_SHIFT), .NBYTES(NBYTES)
    ) u_lookup (
        .addr(mem_addr_i), .bank_q(bank_q), .region(region), .attr(attr)
    );

    lrd_target_sel u_sel (
        .region(region), .attr(attr), .we(mem_we_i), .smm(smm_i),
        .smc_q(smc_q), .tgt(tgt)
    );

    assign tgt_o = tgt;
endmodule

// File: rtl/lrd_chk.sv
module lrd_chk
    import lrd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int NBYTES = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we_i,
    input logic [7:0]          cfg_off_i,
    input logic [7:0]          cfg_wdata_i,
    input logic                smm_i,
    input logic [ADDR_W-1:0]   mem_addr_i,
    input logic                mem_we_i,
    input logic [1:0]          tgt_o,
    input logic [NBYTES*8-1:0] bank_q,
    input logic [7:0]          smc_q
);
    logic in_video, other_off;
    assign in_video  = mem_addr_i >= ADDR_W'(VIDEO_BASE) && mem_addr_i < ADDR_W'(SEG_BASE);
    assign other_off = !(cfg_off_i == SMC_OFF ||
                        (cfg_off_i >= BANK_OFF && cfg_off_i < 8'(BANK_OFF + 8'(NBYTES))));

    // R2
    outside_dram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr_i < ADDR_W'(VIDEO_BASE) || mem_addr_i >= ADDR_W'(WIN_END)) |-> tgt_o == 2'd0);

    // R5
    read_never_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_i |-> tgt_o != 2'd2);

    // R6
    video_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_video && smc_q[SMC_OPEN_BIT]) |-> tgt_o == 2'd0);

    // R7
    video_smm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_video && smm_i && smc_q[SMC_SMM_BIT]) |-> tgt_o == 2'd0);

    // R7
    video_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_video && !smc_q[SMC_OPEN_BIT] && !(smm_i && smc_q[SMC_SMM_BIT])) |-> tgt_o == 2'd1);

    // R8
    smc_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_off_i == SMC_OFF) |=> smc_q == $past(cfg_wdata_i));

    // R9
    other_off_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && other_off) |=> ($stable(bank_q) && $stable(smc_q)));
endmodule

bind legacy_mem_decoder lrd_chk #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we_i), .cfg_off_i(cfg_off_i),
    .cfg_wdata_i(cfg_wdata_i), .smm_i(smm_i), .mem_addr_i(mem_addr_i),
    .mem_we_i(mem_we_i), .tgt_o(tgt_o), .bank_q(bank_q), .smc_q(smc_q)
);

// File: tb/sim_legacy_mem_decoder.sv
`timescale 1ns/1ps
module sim_legacy_mem_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_off = 8'h00;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        smm = 1'b0;
    logic [31:0] addr = 32'h0;
    logic        mem_we = 1'b0;
    logic [1:0]  tgt;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int model [256];

    always #10 clk = ~clk;

    legacy_mem_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_off_i(cfg_off),
        .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata), .smm_i(smm),
        .mem_addr_i(addr), .mem_we_i(mem_we), .tgt_o(tgt)
    );

    function automatic bit writable(int off);
        return (off >= 'h59 && off <= 'h5F) || off == 'h72;
    endfunction

    // behavioural reference: 0 DRAM, 1 bus, 2 dropped
    function automatic int exp_tgt(int a, bit we, bit s);
        int code, seg;
        if (a < 'hA0000 || a >= 'h100000) return 0;
        if (a < 'hC0000) begin
            if (model['h72][6] || (s && model['h72][3])) return 0;
            return 1;
        end
        if (a >= 'hF0000) code = (model['h59] / 16) % 4;
        else begin
            seg  = (a - 'hC0000) / 'h4000;
            code = (seg % 2 == 1) ? (model['h5A + seg/2] / 16) % 4 : model['h5A + seg/2] % 4;
        end
        if (code == 3) return 0;
        if (code == 1) return we ? 2 : 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (model[k]) model[k] = 0;
            model['h72] = 'h02;
        end else if (cfg_we && writable(int'(cfg_off))) begin
            model[int'(cfg_off)] = int'(cfg_wdata);
        end
    end

    task automatic check_now(string req);
        int et, er;
        et = exp_tgt(int'(addr), mem_we, smm);
        er = model[int'(cfg_off)];
        checks++;
        if (int'(tgt) != et) begin
            errors++;
            $display("FAIL %s tgt addr=%h we=%0d: got %0d expected %0d", req, addr, mem_we, tgt, et);
        end
        checks++;
        if (int'(cfg_rdata) != er) begin
            errors++;
            $display("FAIL %s rdata off=%h: got %h expected %h", req, cfg_off, cfg_rdata, er);
        end
    endtask

    // drive at falling edge, compare a quarter period later
    task automatic step(string req, bit we_c, int off, int wd, int a, bit mw, bit s);
        @(negedge clk);
        cfg_we = we_c; cfg_off = 8'(off); cfg_wdata = 8'(wd);
        addr = 32'(a); mem_we = mw; smm = s;
        #5;
        check_now(req);
    endtask

    task automatic wr(string req, int off, int wd);
        step(req, 1'b1, off, wd, 'hF0000, 1'b0, smm);
    endtask

    task automatic rd(string req, int a, bit mw);
        step(req, 1'b0, 'h72, 0, a, mw, smm);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values and all window segments forward to the bus
        step("R1", 0, 'h72, 0, 'hF0000, 0, 0);
        step("R1", 0, 'h5A, 0, 'hC0000, 0, 0);
        step("R1", 0, 'h59, 0, 'hA0000, 1, 0);
        step("R1", 0, 'h5F, 0, 'hEFFFF, 0, 0);
        // R2: outside the window
        rd("R2", 'h9FFFF, 1'b0);
        rd("R2", 'h100000, 1'b1);
        rd("R2", 'h00000, 1'b1);

        // R3 / R8: boot segment, effect from the next cycle
        wr("R8", 'h59, 'h30);
        rd("R3", 'hF8000, 1'b1);
        rd("R3", 'hFFFFF, 1'b0);
        wr("R5", 'h59, 'h10);
        rd("R5", 'hF0000, 1'b0);
        rd("R5", 'hF0000, 1'b1);
        wr("R5", 'h59, 'h20);
        rd("R5", 'hF4000, 1'b0);
        wr("R3", 'h59, 'hC3);
        rd("R3", 'hF0000, 1'b0);

        // R4: option segments with distinct nibbles
        wr("R4", 'h5A, 'h13);
        wr("R4", 'h5B, 'h31);
        wr("R4", 'h5C, 'h20);
        wr("R4", 'h5D, 'h02);
        wr("R4", 'h5E, 'h30);
        wr("R4", 'h5F, 'h01);
        for (int i = 0; i < 12; i++) begin
            rd("R4", 'hC0000 + 'h4000 * i, 1'b0);
            rd("R4", 'hC0000 + 'h4000 * i, 1'b1);
            rd("R4", 'hC0000 + 'h4000 * i + 'h3FFF, 1'b1);
        end
        wr("R4", 'h5A, 'hCC);
        rd("R4", 'hC0000, 1'b0);
        rd("R4", 'hC4000, 1'b1);

        // R6 / R7: video area
        wr("R6", 'h72, 'h40);
        rd("R6", 'hA0000, 1'b1);
        rd("R6", 'hBFFFF, 1'b0);
        wr("R7", 'h72, 'h08);
        step("R7", 0, 'h72, 0, 'hA8000, 0, 0);
        step("R7", 0, 'h72, 0, 'hA8000, 0, 1);
        step("R7", 0, 'h72, 0, 'hA8000, 1, 0);
        wr("R7", 'h72, 'h00);
        step("R7", 0, 'h72, 0, 'hB0000, 0, 1);

        // R9: other offsets ignored
        wr("R9", 'h58, 'hFF);
        wr("R9", 'h60, 'hFF);
        wr("R9", 'h71, 'hFF);
        wr("R9", 'h73, 'hFF);
        step("R9", 0, 'h58, 0, 'hC0000, 1, 0);
        step("R9", 0, 'h60, 0, 'hA0000, 0, 1);
        step("R9", 0, 'h71, 0, 'hF0000, 0, 0);

        // randomized stretch, R8 R9 R5 compared every clock
        for (int n = 0; n < 400; n++) begin
            int o;
            o = ($urandom % 4 == 0) ? 'h72 : ('h57 + int'($urandom % 11));
            step("R8", 1'($urandom % 2), o, int'($urandom % 256),
                 'h98000 + int'($urandom % 'h6A000), 1'($urandom % 2), 1'($urandom % 2));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule